// File: doc/BRIEF.md
# Sixteen-Channel Edge Event Tally

This block counts edge events on sixteen input lines without holding any counters in flip-flops. Each line passes through a synchroniser and an edge detector. When the selected edge (rising or falling) appears on a line that is unmasked, the block latches a pending flag for that line. The event interrupt output stays high while any flag is set.

A single update engine takes one flagged channel at a time, lowest number first. It reads that channel's 16-bit tally from a shared word RAM, adds one, and writes the result back to the same slot. It then clears the flag. The slots form a table of sixteen consecutive 16-bit words that starts at a 32-byte aligned base address.

Software configures the block through four registers with a write strobe and a 2-bit offset. Offset 0 is control: bit 0 is the count enable, bit 1 is the engine enable, and bit 2 selects the falling edge. Offset 1 is the channel mask, with one bit per channel. Offset 2 is the table base as a byte address. Offset 3 returns the pending flags, one bit per channel, and is read-only. Read data is combinational from the offset.

Top module: `evt_tally`

## Requirements
- R1: With the count enable set and the channel's mask bit set, a rising edge on a pin sets that channel's pending flag when falling select (control bit 2) is 0. A pin level that changes before clock edge k is visible in the flags after edge k+2.
- R2: When falling select is 1, only a falling edge sets the flag, and a rising edge does not.
- R3: A channel whose mask bit is 0 never sets its pending flag.
- R4: While the count enable (control bit 0) is 0, no pending flag is set. Setting the enable while a pin already sits at its active level produces no event.
- R5: The interrupt output is high exactly while at least one pending flag is set. It falls only in the cycle after a RAM write.
- R6: Offset 3 reads the pending flags, with bit n for channel n, and writes to offset 3 have no effect. All registers and flags read 0 after reset.
- R7: The engine issues RAM accesses only while both the count enable and the engine enable (control bit 1) are set. While the engine enable is 0, flags stay held and no RAM access takes place.
- R8: When several flags are pending, the lowest-numbered channel is updated first.
- R9: The slot of channel n is at byte address base + 2*n. A write to offset 2 stores bits [15:5] and forces bits [4:0] to zero.
- R10: One update takes three cycles: a read of the slot, one cycle to add one, and a write of the sum to the same address. A flag set before edge k+2 produces a read in the cycle after k+3 and a write in the cycle after k+5. The flag is clear after the write.
- R11: Further edges on a channel whose flag is already set add no extra count.
- R12: An edge whose flag-set coincides with the clearing write keeps the flag set, and a second update follows.
- R13: A tally of 16'hFFFF becomes 16'h0000 with no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pin | input | 16 | Asynchronous event lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| evt_irq | output | 1 | Event interrupt request |
| ram_addr | output | 16 | Byte address of the slot being updated |
| ram_re | output | 1 | RAM read strobe; data is returned the next cycle |
| ram_we | output | 1 | RAM write strobe |
| ram_wdata | output | 16 | Incremented tally |
| ram_rdata | input | 16 | RAM read data |

## Verification
A corrupted flag or engine state shows at the ports within a few cycles. A lost flag drops the interrupt early, and a stuck flag keeps it high. A wrong latched channel writes to the wrong slot on the very next write strobe. A scoreboard compares every write strobe against the expected address and tally, so both a misordered service and a double count are caught at the first wrong write. A missing update is caught when the expected-write queue fails to drain. The edge-collision case is driven with exact cycle timing, so that a clear that wins over a set leaves an expected write unmatched.

// File: rtl/evt_tally_pkg.sv
`timescale 1ns/1ps
package evt_tally_pkg;
   typedef enum logic [1:0] {ENG_IDLE, ENG_READ, ENG_BUMP, ENG_WRITE} eng_state_t;
   localparam logic [1:0] OFS_CTRL = 2'd0;
   localparam logic [1:0] OFS_MASK = 2'd1;
   localparam logic [1:0] OFS_BASE = 2'd2;
   localparam logic [1:0] OFS_PEND = 2'd3;
   localparam int CTRL_CNT_EN = 0;
   localparam int CTRL_ENG_EN = 1;
   localparam int CTRL_FALL   = 2;
   localparam int CTRL_W      = 3;
endpackage

// File: rtl/evt_tally_edge.sv
`timescale 1ns/1ps
module evt_tally_edge #(
   parameter int SYNC_STAGES = 2,
   parameter bit IDLE_LEVEL  = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic arm,
   input  logic fall_sel,
   output logic hit
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   hist_q;
   logic                   lvl;

   assign lvl = sync_q[SYNC_STAGES-1];

   // history follows the synchronised level every cycle, so arming never
   // sees a stale level and cannot raise a spurious event
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= {SYNC_STAGES{IDLE_LEVEL}};
         hist_q <= IDLE_LEVEL;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
         hist_q <= lvl;
      end
   end

   always_comb begin
      if (fall_sel) hit = arm & hist_q & ~lvl;
      else          hit = arm & ~hist_q & lvl;
   end
endmodule

// File: rtl/evt_tally_pick.sv
`timescale 1ns/1ps
module evt_tally_pick #(
   parameter int NCH       = 16,
   parameter int IW        = 4,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic [NCH-1:0] req,
   output logic           any,
   output logic [IW-1:0]  idx
);
   assign any = |req;

   generate
      if (LOW_FIRST) begin : g_low
         always_comb begin
            idx = '0;
            for (int i = NCH - 1; i >= 0; i--)
               if (req[i]) idx = IW'(i);
         end
      end else begin : g_high
         always_comb begin
            idx = '0;
            for (int i = 0; i < NCH; i++)
               if (req[i]) idx = IW'(i);
         end
      end
   endgenerate
endmodule

// File: rtl/evt_tally_engine.sv
`timescale 1ns/1ps
module evt_tally_engine
   import evt_tally_pkg::*;
#(
   parameter int NCH   = 16,
   parameter int CW    = 16,
   parameter int AW    = 16,
   parameter int IW    = 4,
   parameter int SHIFT = 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           run,
   input  logic           any_pend,
   input  logic [IW-1:0]  pick_idx,
   input  logic [AW-1:0]  base,
   output logic [AW-1:0]  ram_addr,
   output logic           ram_re,
   output logic           ram_we,
   output logic [CW-1:0]  ram_wdata,
   input  logic [CW-1:0]  ram_rdata,
   output logic [NCH-1:0] clr
);
   eng_state_t      state_q;
   logic [IW-1:0]   cur_q;
   logic [AW-1:0]   addr_q;
   logic [CW-1:0]   acc_q;
   logic [AW-1:0]   slot_ofs;

   assign slot_ofs = AW'(pick_idx) << SHIFT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ENG_IDLE;
         cur_q   <= '0;
         addr_q  <= '0;
         acc_q   <= '0;
      end else begin
         unique case (state_q)
            ENG_IDLE: begin
               if (run && any_pend) begin
                  cur_q   <= pick_idx;
                  addr_q  <= base + slot_ofs;
                  state_q <= ENG_READ;
               end
            end
            ENG_READ: state_q <= ENG_BUMP;
            ENG_BUMP: begin
               acc_q   <= ram_rdata + CW'(1);
               state_q <= ENG_WRITE;
            end
            ENG_WRITE: state_q <= ENG_IDLE;
            default:   state_q <= ENG_IDLE;
         endcase
      end
   end

   assign ram_addr  = addr_q;
   assign ram_re    = (state_q == ENG_READ);
   assign ram_we    = (state_q == ENG_WRITE);
   assign ram_wdata = acc_q;

   always_comb begin
      for (int i = 0; i < NCH; i++)
         clr[i] = (state_q == ENG_WRITE) && (cur_q == IW'(i));
   end
endmodule

// File: rtl/evt_tally_regs.sv
`timescale 1ns/1ps
module evt_tally_regs
   import evt_tally_pkg::*;
#(
   parameter int NCH   = 16,
   parameter int AW    = 16,
   parameter int RW    = 16,
   parameter int ALIGN = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           reg_we,
   input  logic [1:0]     reg_addr,
   input  logic [RW-1:0]  reg_wdata,
   output logic [RW-1:0]  reg_rdata,
   input  logic [NCH-1:0] set_vec,
   input  logic [NCH-1:0] clr_vec,
   output logic           cnt_en,
   output logic           eng_en,
   output logic           fall_sel,
   output logic [NCH-1:0] chan_mask,
   output logic [AW-1:0]  base,
   output logic [NCH-1:0] pend
);
   logic [CTRL_W-1:0]   ctrl_q;
   logic [NCH-1:0]      mask_q;
   logic [AW-1:ALIGN]   base_q;
   logic [NCH-1:0]      pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         mask_q <= '0;
         base_q <= '0;
      end else if (reg_we) begin
         unique case (reg_addr)
            OFS_CTRL: ctrl_q <= reg_wdata[CTRL_W-1:0];
            OFS_MASK: mask_q <= reg_wdata[NCH-1:0];
            OFS_BASE: base_q <= reg_wdata[AW-1:ALIGN];
            default:  ;
         endcase
      end
   end

   // a set arriving with the clear wins, so a late edge is kept
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr_vec) | set_vec;
   end

   always_comb begin
      unique case (reg_addr)
         OFS_CTRL: reg_rdata = RW'(ctrl_q);
         OFS_MASK: reg_rdata = RW'(mask_q);
         OFS_BASE: reg_rdata = RW'(base);
         default:  reg_rdata = RW'(pend_q);
      endcase
   end

   assign cnt_en    = ctrl_q[CTRL_CNT_EN];
   assign eng_en    = ctrl_q[CTRL_ENG_EN];
   assign fall_sel  = ctrl_q[CTRL_FALL];
   assign chan_mask = mask_q;
   assign base      = {base_q, {ALIGN{1'b0}}};
   assign pend      = pend_q;
endmodule

// File: rtl/evt_tally.sv
`timescale 1ns/1ps
module evt_tally #(
   parameter int NCH         = 16,
   parameter int CW          = 16,
   parameter int AW          = 16,
   parameter int RW          = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit LOW_FIRST   = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] evt_pin,
   input  logic           reg_we,
   input  logic [1:0]     reg_addr,
   input  logic [RW-1:0]  reg_wdata,
   output logic [RW-1:0]  reg_rdata,
   output logic           evt_irq,
   output logic [AW-1:0]  ram_addr,
   output logic           ram_re,
   output logic           ram_we,
   output logic [CW-1:0]  ram_wdata,
   input  logic [CW-1:0]  ram_rdata
);
   localparam int STRIDE = CW / 8;
   localparam int SHIFT  = $clog2(STRIDE);
   localparam int ALIGN  = $clog2(NCH * STRIDE);
   localparam int IW     = (NCH > 1) ? $clog2(NCH) : 1;

   generate
      if (NCH < 2) begin : g_bad_nch
         $error("evt_tally: NCH must be at least 2");
      end
      if ((CW % 8) != 0 || (1 << SHIFT) != STRIDE) begin : g_bad_cw
         $error("evt_tally: CW must be a power-of-two number of bytes");
      end
      if ((1 << IW) != NCH) begin : g_bad_pow
         $error("evt_tally: NCH must be a power of two");
      end
      if (AW <= ALIGN) begin : g_bad_aw
         $error("evt_tally: AW too small for the slot table");
      end
      if (RW < NCH || RW < AW || RW < 3) begin : g_bad_rw
         $error("evt_tally: RW narrower than a register");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("evt_tally: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic           cnt_en, eng_en, fall_sel, run, any_pend;
   logic [NCH-1:0] chan_mask, set_vec, clr_vec, pend;
   logic [AW-1:0]  base;
   logic [IW-1:0]  pick_idx;

   assign run = cnt_en & eng_en;

   generate
      for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
         evt_tally_edge #(
            .SYNC_STAGES (SYNC_STAGES),
            .IDLE_LEVEL  (1'b0)
         ) u_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin      (evt_pin[ch]),
            .arm      (cnt_en & chan_mask[ch]),
            .fall_sel (fall_sel),
            .hit      (set_vec[ch])
         );
      end
   endgenerate

   evt_tally_regs #(
      .NCH (NCH), .AW (AW), .RW (RW), .ALIGN (ALIGN)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .set_vec   (set_vec),
      .clr_vec   (clr_vec),
      .cnt_en    (cnt_en),
      .eng_en    (eng_en),
      .fall_sel  (fall_sel),
      .chan_mask (chan_mask),
      .base      (base),
      .pend      (pend)
   );

   evt_tally_pick #(
      .NCH (NCH), .IW (IW), .LOW_FIRST (LOW_FIRST)
   ) u_pick (
      .req (pend),
      .any (any_pend),
      .idx (pick_idx)
   );

   evt_tally_engine #(
      .NCH (NCH), .CW (CW), .AW (AW), .IW (IW), .SHIFT (SHIFT)
   ) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .any_pend  (any_pend),
      .pick_idx  (pick_idx),
      .base      (base),
      .ram_addr  (ram_addr),
      .ram_re    (ram_re),
      .ram_we    (ram_we),
      .ram_wdata (ram_wdata),
      .ram_rdata (ram_rdata),
      .clr       (clr_vec)
   );

   assign evt_irq = |pend;
endmodule

// File: rtl/evt_tally_chk.sv
`timescale 1ns/1ps
module evt_tally_chk #(
   parameter int NCH   = 16,
   parameter int CW    = 16,
   parameter int AW    = 16,
   parameter int ALIGN = 5
) (
   input logic           clk,
   input logic           rst_n,
   input logic [NCH-1:0] pend,
   input logic [NCH-1:0] set_vec,
   input logic [NCH-1:0] clr_vec,
   input logic           evt_irq,
   input logic           ram_re,
   input logic           ram_we,
   input logic [AW-1:0]  ram_addr,
   input logic [CW-1:0]  ram_wdata,
   input logic [CW-1:0]  ram_rdata,
   input logic [AW-1:0]  base,
   input logic           cnt_en,
   input logic           run
);
   AST_NO_FLAG_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_en |=> ((pend & ~$past(pend)) == '0)); // R4

   AST_IRQ_FALLS_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(evt_irq) |-> $past(ram_we)); // R5

   AST_READ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      ram_re |-> $past(run)); // R7

   AST_SLOT_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
      ram_re |-> (ram_addr[AW-1:ALIGN] == base[AW-1:ALIGN]) && !ram_addr[0]); // R9

   AST_WRITE_SAME_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> $past(ram_re, 2) && ($past(ram_addr, 2) == ram_addr)); // R10

   AST_SINGLE_PORT_USE: assert property (@(posedge clk) disable iff (!rst_n)
      !(ram_re && ram_we) && $onehot0(clr_vec)); // R10

   AST_COLLIDING_SET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      |(set_vec & clr_vec) |=> ((pend & $past(set_vec & clr_vec)) == $past(set_vec & clr_vec))); // R12

   AST_WRITE_IS_PLUS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> (ram_wdata == CW'($past(ram_rdata) + CW'(1)))); // R13
endmodule

bind evt_tally evt_tally_chk #(
   .NCH (NCH), .CW (CW), .AW (AW), .ALIGN (ALIGN)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pend      (pend),
   .set_vec   (set_vec),
   .clr_vec   (clr_vec),
   .evt_irq   (evt_irq),
   .ram_re    (ram_re),
   .ram_we    (ram_we),
   .ram_addr  (ram_addr),
   .ram_wdata (ram_wdata),
   .ram_rdata (ram_rdata),
   .base      (base),
   .cnt_en    (cnt_en),
   .run       (run)
);

// File: tb/evt_tally_test.sv
`timescale 1ns/1ps
module evt_tally_test;
   localparam int NCH = 16;
   localparam int CW  = 16;
   localparam int AW  = 16;
   localparam int RW  = 16;

   logic           clk = 1'b0;
   logic           rst_n;
   logic [NCH-1:0] pins;
   logic           reg_we;
   logic [1:0]     reg_addr;
   logic [RW-1:0]  reg_wdata;
   logic [RW-1:0]  reg_rdata;
   logic           evt_irq;
   logic [AW-1:0]  ram_addr;
   logic           ram_re, ram_we;
   logic [CW-1:0]  ram_wdata;
   logic [CW-1:0]  ram_rdata;

   always #4 clk = ~clk;

   evt_tally uut (
      .clk (clk), .rst_n (rst_n), .evt_pin (pins),
      .reg_we (reg_we), .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
      .evt_irq (evt_irq), .ram_addr (ram_addr), .ram_re (ram_re), .ram_we (ram_we),
      .ram_wdata (ram_wdata), .ram_rdata (ram_rdata)
   );

   // word RAM model, one-cycle read latency
   logic [CW-1:0] mem [int];
   always @(posedge clk) begin
      if (ram_re) ram_rdata <= mem.exists(int'(ram_addr >> 1)) ? mem[int'(ram_addr >> 1)] : '0;
      if (ram_we) mem[int'(ram_addr >> 1)] = ram_wdata;
   end

   typedef struct packed {
      logic [AW-1:0] addr;
      logic [CW-1:0] data;
   } item_t;

   item_t         sbq[$];
   logic [CW-1:0] model [NCH];
   logic [AW-1:0] base_exp;
   int            checks = 0;
   int            fails  = 0;
   bit            timed_out = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic expect_bump(input int ch);
      model[ch] = model[ch] + CW'(1);
      sbq.push_back('{addr: base_exp + AW'(ch * 2), data: model[ch]});
   endtask

   // monitor: every write strobe is compared with the next expected item
   always @(negedge clk) begin
      item_t it;
      if (rst_n && ram_we) begin
         if (sbq.size() == 0) begin
            check(1'b0, "R7", "write with nothing expected", ram_addr, 0);
         end else begin
            it = sbq.pop_front();
            check(ram_addr == it.addr, "R8 R9", "write address", ram_addr, it.addr);
            check(ram_wdata == it.data, "R10 R11 R13", "written tally", ram_wdata, it.data);
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [RW-1:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] a, output logic [RW-1:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic pulse(input logic [NCH-1:0] m);
      @(negedge clk);
      pins = pins | m;
      idle(3);
      pins = pins & ~m;
      idle(3);
   endtask

   task automatic run_all();
      logic [RW-1:0] rd;
      // reset state
      check(evt_irq == 1'b0, "R6", "irq after reset", evt_irq, 0);
      check(!ram_re && !ram_we, "R6", "ram strobes after reset", {ram_re, ram_we}, 0);
      reg_read(2'd3, rd);
      check(rd == '0, "R6", "pending after reset", rd, 0);
      reg_read(2'd0, rd);
      check(rd == '0, "R6", "control after reset", rd, 0);

      // base alignment
      reg_write(2'd2, 16'h1234);
      reg_read(2'd2, rd);
      check(rd == 16'h1220, "R9", "base readback", rd, 16'h1220);
      base_exp = 16'h1220;
      reg_write(2'd1, 16'hFFFF);
      reg_write(2'd0, 16'h0003);

      // exact latency on channel 0
      expect_bump(0);
      @(negedge clk); pins[0] = 1'b1;          // before edge k
      @(negedge clk);                          // after k
      @(negedge clk);                          // after k+1
      check(evt_irq == 1'b0, "R1", "flag too early", evt_irq, 0);
      @(negedge clk);                          // after k+2
      check(evt_irq == 1'b1, "R1 R5", "flag after k+2", evt_irq, 1);
      @(negedge clk);                          // after k+3
      check(ram_re == 1'b1, "R10", "read cycle", ram_re, 1);
      @(negedge clk);
      check(!ram_re && !ram_we, "R10", "add cycle", {ram_re, ram_we}, 0);
      @(negedge clk);                          // after k+5
      check(ram_we == 1'b1, "R10", "write cycle", ram_we, 1);
      @(negedge clk);
      check(evt_irq == 1'b0, "R5 R10", "flag cleared after write", evt_irq, 0);
      pins[0] = 1'b0;
      idle(4);

      // a few single channels
      expect_bump(5);  pulse(16'h0020); idle(6);
      expect_bump(10); pulse(16'h0400); idle(6);
      expect_bump(5);  pulse(16'h0020); idle(6);

      // engine held off: flags collect, priority on release
      reg_write(2'd0, 16'h0001);
      pulse(16'h1210);
      pulse(16'h0010);                         // R11 second edge on a set flag
      reg_read(2'd3, rd);
      check(rd == 16'h1210, "R6 R7 R11", "held pending flags", rd, 16'h1210);
      check(evt_irq == 1'b1, "R5", "irq with flags held", evt_irq, 1);
      reg_write(2'd3, 16'h0000);
      reg_read(2'd3, rd);
      check(rd == 16'h1210, "R6", "write to pending ignored", rd, 16'h1210);
      expect_bump(4); expect_bump(9); expect_bump(12);
      reg_write(2'd0, 16'h0003);
      idle(20);
      check(evt_irq == 1'b0, "R8", "all held flags serviced", evt_irq, 0);

      // masked channel
      reg_write(2'd1, 16'hFFBF);
      pulse(16'h0040);
      reg_read(2'd3, rd);
      check(rd == '0, "R3", "masked channel flag", rd, 0);
      reg_write(2'd1, 16'hFFFF);

      // wrap
      mem[int'(base_exp >> 1) + 3] = 16'hFFFF;
      model[3] = 16'hFFFF;
      expect_bump(3);
      pulse(16'h0008); idle(8);

      // count enable off: no flags
      reg_write(2'd0, 16'h0000);
      pulse(16'h0100);
      reg_read(2'd3, rd);
      check(rd == '0, "R4", "flag while disabled", rd, 0);
      // enabling with pin already high: no event
      pins[8] = 1'b1; idle(4);
      reg_write(2'd0, 16'h0003); idle(6);
      reg_read(2'd3, rd);
      check(rd == '0, "R4", "spurious event on enable", rd, 0);
      pins[8] = 1'b0; idle(4);

      // falling edge selection
      reg_write(2'd0, 16'h0000);
      pins[1] = 1'b1; idle(4);
      reg_write(2'd0, 16'h0007); idle(6);
      reg_read(2'd3, rd);
      check(rd == '0, "R2 R4", "no event on enable with falling select", rd, 0);
      expect_bump(1);
      pins[1] = 1'b0; idle(12);
      pins[1] = 1'b1; idle(6);
      reg_read(2'd3, rd);
      check(rd == '0, "R2", "rising edge ignored with falling select", rd, 0);
      reg_write(2'd0, 16'h0000);
      pins[1] = 1'b0; idle(4);
      reg_write(2'd0, 16'h0003); idle(4);

      // edge colliding with the clearing write
      expect_bump(7); expect_bump(7);
      @(negedge clk); pins[7] = 1'b1;          // before edge k
      @(negedge clk); @(negedge clk); pins[7] = 1'b0;   // before k+2
      @(negedge clk); @(negedge clk); pins[7] = 1'b1;   // before k+4
      idle(20);
      pins[7] = 1'b0; idle(8);
      check(evt_irq == 1'b0, "R12", "irq after collision updates", evt_irq, 0);
      check(sbq.size() == 0, "R10 R12", "expected writes left over", sbq.size(), 0);
   endtask

   initial begin
      rst_n = 1'b0; pins = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
      base_exp = '0;
      for (int i = 0; i < NCH; i++) model[i] = '0;
      idle(3);
      rst_n = 1'b1;
      idle(1);
      fork
         run_all();
         begin
            repeat (100000) @(posedge clk);
            timed_out = 1'b1;
         end
      join_any
      disable fork;
      if (timed_out) check(1'b0, "R10", "watchdog expired", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule